// File: doc/BRIEF.md
# CAN Bus-Off Recovery Sequencer

This block supervises the return of a CAN controller from the bus-off state. It holds the controller's initialization flag. The flag is forced to 1 whenever a bus-off event arrives, and while it is 1 the node takes no part in bus traffic. Software must clear the flag before recovery can begin. After that, the block samples the received bit on every bit-time strobe and counts runs of eleven consecutive recessive bits. It reports each finished run to the status logic as a "bit-0 error" code.

When the required number of runs has been seen, the block pulses a reset to the transmit and receive error counters and lets the node back onto the bus. Software cannot shorten the wait by toggling the flag. Setting it during recovery only pauses the count. The block also gates write access to the bit-timing configuration: such writes are allowed only while the flag is set and the configuration-change enable is on.

Top module: `can_busoff_recovery`

## Requirements
- R1: After reset, init_o is 1, bus_active_o is 0, sts_code_o is 3'b000, and sts_wr_o and ec_reset_o are 0.
- R2: A cycle with bus_off_i high makes init_o 1 on the next cycle, even when a software write of 0 to INIT arrives in the same cycle. bus_active_o is 0 in every cycle in which init_o is 1.
- R3: A cycle with init_wr_i high loads init_wdata_i into init_o on the next cycle, unless bus_off_i is also high. Outside recovery, clearing INIT raises bus_active_o on the next cycle without any idle wait.
- R4: After a bus-off, no bit strobe is counted while init_o is 1. Counting starts with the first strobe after init_o reads 0.
- R5: A run completes at the 11th consecutive strobe that samples rx_bit_i = 1. One cycle after that strobe, sts_wr_o is high for exactly one cycle and sts_code_o reads 3'b101. sts_code_o holds that value afterwards. Values on rx_bit_i in cycles without a strobe are ignored.
- R6: A strobe that samples rx_bit_i = 0 restarts the current 11-bit run from zero. It leaves the number of completed runs unchanged.
- R7: One cycle after the strobe that completes the 129th run, ec_reset_o is high for exactly one cycle and bus_active_o rises in that same cycle. A later bus-off again needs the full 129 runs.
- R8: Writing INIT to 1 during recovery freezes both the current run and the completed-run count. Clearing INIT again resumes from the frozen values, with no restart and no skip.
- R9: A bus-off event during recovery restarts both counts from zero.
- R10: timing_wr_en_o is 1 exactly when cce_i is 1 and init_o is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bit_strobe_i | input | 1 | One-cycle pulse once per bit time |
| rx_bit_i | input | 1 | Received bus level (1 = recessive) |
| bus_off_i | input | 1 | Bus-off entry event |
| init_wr_i | input | 1 | Software write strobe for INIT |
| init_wdata_i | input | 1 | Value written to INIT |
| cce_i | input | 1 | Configuration-change enable |
| init_o | output | 1 | Initialization flag |
| sts_code_o | output | 3 | Status error code (3'b101 = bit-0 error) |
| sts_wr_o | output | 1 | One-cycle write strobe for sts_code_o |
| ec_reset_o | output | 1 | One-cycle error-counter reset |
| bus_active_o | output | 1 | Node may take part in bus traffic |
| timing_wr_en_o | output | 1 | Bit-timing register write permitted |

## Verification
The hardest condition to reach from the ports is the final step of recovery. The 129th run has to complete on an exact strobe, after 1419 recessive samples, while the pauses, dominant glitches and INIT toggles that the bench injects along the way must not shift that strobe by even one bit. Directed sequences drive complete recoveries with gaps between strobes, a dominant bit in the middle of a run, and a software pause partway through. A seeded random phase then keeps rx_bit_i mostly recessive and makes bus-off and INIT writes rare, so that several further recoveries finish under mixed stimulus. A bench reference model predicts every output cycle by cycle.

// File: rtl/can_bor_pkg.sv
package can_bor_pkg;
  typedef enum logic {
    ST_NORMAL  = 1'b0,
    ST_RECOVER = 1'b1
  } bor_state_e;

  localparam int unsigned CODE_W = 3;
  localparam logic [CODE_W-1:0] CODE_NONE = 3'b000;
  localparam logic [CODE_W-1:0] CODE_BIT0 = 3'b101;
endpackage

// File: rtl/can_bor_run_cnt.sv
// Counts consecutive recessive samples; flags the sample that completes a run.
module can_bor_run_cnt #(
  parameter int unsigned RUN_LEN = 11
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic en_i,
  input  logic bit_i,
  output logic run_done_o
);
  localparam int unsigned RunW = (RUN_LEN > 2) ? $clog2(RUN_LEN) : 1;
  localparam logic [RunW-1:0] RunLast = RunW'(RUN_LEN - 1);

  logic [RunW-1:0] cnt_q;

  assign run_done_o = en_i && bit_i && !clr_i && (cnt_q == RunLast);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (clr_i) begin
      cnt_q <= '0;
    end else if (en_i) begin
      if (!bit_i || run_done_o) cnt_q <= '0;
      else                      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/can_bor_idle_cnt.sv
// Counts completed idle runs; flags the run that ends recovery.
module can_bor_idle_cnt #(
  parameter int unsigned RUN_COUNT = 129
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic inc_i,
  output logic last_o
);
  localparam int unsigned IdleW = (RUN_COUNT > 2) ? $clog2(RUN_COUNT) : 1;
  localparam logic [IdleW-1:0] IdleLast = IdleW'(RUN_COUNT - 1);

  logic [IdleW-1:0] cnt_q;

  assign last_o = inc_i && !clr_i && (cnt_q == IdleLast);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (clr_i || last_o) begin
      cnt_q <= '0;
    end else if (inc_i) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/can_bor_ctrl.sv
// INIT flag, recovery state and registered status outputs.
module can_bor_ctrl
  import can_bor_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_off_i,
  input  logic              init_wr_i,
  input  logic              init_wdata_i,
  input  logic              cce_i,
  input  logic              run_done_i,
  input  logic              seq_done_i,
  output logic              counting_o,
  output logic              restart_o,
  output logic              init_o,
  output logic [CODE_W-1:0] sts_code_o,
  output logic              sts_wr_o,
  output logic              ec_reset_o,
  output logic              bus_active_o,
  output logic              timing_wr_en_o
);
  bor_state_e        state_q;
  logic              init_q;
  logic [CODE_W-1:0] code_q;
  logic              sts_wr_q;
  logic              ec_reset_q;

  assign restart_o  = bus_off_i;
  assign counting_o = (state_q == ST_RECOVER) && !init_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_NORMAL;
    end else if (bus_off_i) begin
      state_q <= ST_RECOVER;
    end else if (seq_done_i) begin
      state_q <= ST_NORMAL;
    end
  end

  // bus-off outranks a software write
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        init_q <= 1'b1;
    else if (bus_off_i) init_q <= 1'b1;
    else if (init_wr_i) init_q <= init_wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      code_q     <= CODE_NONE;
      sts_wr_q   <= 1'b0;
      ec_reset_q <= 1'b0;
    end else begin
      sts_wr_q   <= run_done_i;
      ec_reset_q <= seq_done_i;
      if (run_done_i) code_q <= CODE_BIT0;
    end
  end

  assign init_o         = init_q;
  assign sts_code_o     = code_q;
  assign sts_wr_o       = sts_wr_q;
  assign ec_reset_o     = ec_reset_q;
  assign bus_active_o   = (state_q == ST_NORMAL) && !init_q;
  assign timing_wr_en_o = cce_i && init_q;
endmodule

// File: rtl/can_busoff_recovery.sv
module can_busoff_recovery
  import can_bor_pkg::*;
#(
  parameter int unsigned RUN_LEN   = 11,
  parameter int unsigned RUN_COUNT = 129
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bit_strobe_i,
  input  logic              rx_bit_i,
  input  logic              bus_off_i,
  input  logic              init_wr_i,
  input  logic              init_wdata_i,
  input  logic              cce_i,
  output logic              init_o,
  output logic [CODE_W-1:0] sts_code_o,
  output logic              sts_wr_o,
  output logic              ec_reset_o,
  output logic              bus_active_o,
  output logic              timing_wr_en_o
);
  logic counting;
  logic restart;
  logic run_done;
  logic seq_done;

  can_bor_run_cnt #(.RUN_LEN(RUN_LEN)) u_run (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (restart),
    .en_i      (bit_strobe_i && counting),
    .bit_i     (rx_bit_i),
    .run_done_o(run_done)
  );

  can_bor_idle_cnt #(.RUN_COUNT(RUN_COUNT)) u_idle (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (restart),
    .inc_i (run_done),
    .last_o(seq_done)
  );

  can_bor_ctrl u_ctrl (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .bus_off_i     (bus_off_i),
    .init_wr_i     (init_wr_i),
    .init_wdata_i  (init_wdata_i),
    .cce_i         (cce_i),
    .run_done_i    (run_done),
    .seq_done_i    (seq_done),
    .counting_o    (counting),
    .restart_o     (restart),
    .init_o        (init_o),
    .sts_code_o    (sts_code_o),
    .sts_wr_o      (sts_wr_o),
    .ec_reset_o    (ec_reset_o),
    .bus_active_o  (bus_active_o),
    .timing_wr_en_o(timing_wr_en_o)
  );
endmodule

// File: rtl/can_busoff_recovery_chk.sv
module can_busoff_recovery_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       bit_strobe_i,
  input logic       rx_bit_i,
  input logic       bus_off_i,
  input logic       init_wr_i,
  input logic       init_wdata_i,
  input logic       cce_i,
  input logic       init_o,
  input logic [2:0] sts_code_o,
  input logic       sts_wr_o,
  input logic       ec_reset_o,
  input logic       bus_active_o,
  input logic       timing_wr_en_o
);
  AST_BUSOFF_SETS_INIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_off_i |=> init_o); // R2
  AST_INIT_BLOCKS_BUS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    init_o |-> !bus_active_o); // R2
  AST_STS_CODE_BIT0: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sts_wr_o |-> sts_code_o == 3'b101); // R5
  AST_STS_NEEDS_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sts_wr_o |-> $past(bit_strobe_i && rx_bit_i && !init_o)); // R4
  AST_STS_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sts_wr_o && !$past(bus_off_i) |=> !sts_wr_o || $past(bit_strobe_i)); // R5
  AST_EC_WITH_ACTIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ec_reset_o |-> bus_active_o && sts_wr_o); // R7
  AST_EC_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ec_reset_o |=> !ec_reset_o); // R7
  AST_TIMING_NEEDS_INIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    timing_wr_en_o |-> init_o && cce_i); // R10
endmodule

bind can_busoff_recovery can_busoff_recovery_chk u_chk (.*);

// File: tb/can_busoff_recovery_test.sv
`timescale 1ns/1ps
module can_busoff_recovery_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       strobe = 1'b0, rx = 1'b1, boff = 1'b0, iwr = 1'b0, iwd = 1'b0, cce = 1'b0;
  logic       init_o, sts_wr_o, ec_reset_o, bus_active_o, timing_wr_en_o;
  logic [2:0] sts_code_o;

  int checks = 0, fails = 0;
  bit done = 1'b0;

  // reference model state
  bit         m_init = 1'b1, m_rec = 1'b0, m_sts = 1'b0, m_ec = 1'b0;
  int         m_run = 0, m_idle = 0;
  logic [2:0] m_code = 3'b000;

  always #5 clk = ~clk;

  can_busoff_recovery uut (
    .clk_i(clk), .rst_ni(rst_n), .bit_strobe_i(strobe), .rx_bit_i(rx),
    .bus_off_i(boff), .init_wr_i(iwr), .init_wdata_i(iwd), .cce_i(cce),
    .init_o(init_o), .sts_code_o(sts_code_o), .sts_wr_o(sts_wr_o),
    .ec_reset_o(ec_reset_o), .bus_active_o(bus_active_o), .timing_wr_en_o(timing_wr_en_o)
  );

  function automatic logic [7:0] exp_vec(bit c);
    return {m_init, m_code, m_sts, m_ec, (!m_rec && !m_init), (c && m_init)};
  endfunction

  function automatic logic [7:0] act_vec();
    return {init_o, sts_code_o, sts_wr_o, ec_reset_o, bus_active_o, timing_wr_en_o};
  endfunction

  // advance model by one clock edge given the inputs
  function automatic void model_edge(bit s, bit r, bit b, bit w, bit d);
    bit counting = m_rec && !m_init;
    m_sts = 1'b0;
    m_ec  = 1'b0;
    if (b) begin
      m_init = 1'b1; m_rec = 1'b1; m_run = 0; m_idle = 0;
    end else begin
      if (counting && s) begin
        if (!r) m_run = 0;
        else if (m_run == 10) begin
          m_run = 0; m_sts = 1'b1; m_code = 3'b101;
          if (m_idle == 128) begin m_idle = 0; m_ec = 1'b1; m_rec = 1'b0; end
          else m_idle++;
        end else m_run++;
      end
      if (w) m_init = d;
    end
  endfunction

  task automatic check(string req);
    checks++;
    if (act_vec() !== exp_vec(cce)) begin
      fails++;
      $display("FAIL %s: actual {init,code,sts_wr,ec,active,twe}=%b expected %b at %0t",
               req, act_vec(), exp_vec(cce), $time);
    end
  endtask

  task automatic step(bit s, bit r, bit b, bit w, bit d, bit c, string req);
    strobe = s; rx = r; boff = b; iwr = w; iwd = d; cce = c;
    model_edge(s, r, b, w, d);
    @(posedge clk);
    @(negedge clk);
    check(req);
  endtask

  task automatic strobes(int n, bit r, string req);
    for (int i = 0; i < n; i++) step(1'b1, r, 1'b0, 1'b0, 1'b0, 1'b0, req);
  endtask

  task automatic expect_bit(string req, string what, bit act, bit exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: %s actual %0b expected %0b", req, what, act, exp);
    end
  endtask

  initial begin
    #1900000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_0c4b));
    repeat (3) @(negedge clk);
    check("R1");
    rst_n = 1'b1;
    @(negedge clk);
    check("R1");
    expect_bit("R1", "sts_code zero", sts_code_o == 3'b000, 1'b1);

    // R10 gating, then R3 clear INIT outside recovery
    step(0, 1, 0, 0, 0, 1, "R10");
    step(0, 1, 0, 1, 0, 1, "R3");
    expect_bit("R3", "bus_active after clear", bus_active_o, 1'b1);
    expect_bit("R10", "twe with init 0", timing_wr_en_o, 1'b0);

    // R2 bus-off wins over same-cycle clear
    step(0, 1, 1, 1, 0, 1, "R2");
    expect_bit("R2", "init after busoff", init_o, 1'b1);
    expect_bit("R2", "bus inactive", bus_active_o, 1'b0);

    // R4 strobes ignored while INIT set
    strobes(30, 1'b1, "R4");
    step(0, 1, 0, 1, 0, 0, "R4");
    // R5 non-strobe dominant ignored, R6 dominant strobe restarts run
    strobes(10, 1'b1, "R6");
    step(0, 0, 0, 0, 0, 0, "R5");
    step(1, 0, 0, 0, 0, 0, "R6");
    strobes(10, 1'b1, "R6");
    expect_bit("R6", "no run after 10", sts_wr_o, 1'b0);
    step(0, 0, 0, 0, 0, 0, "R5");
    step(1, 1, 0, 0, 0, 0, "R5");
    expect_bit("R5", "sts_wr on 11th", sts_wr_o, 1'b1);
    step(0, 1, 0, 0, 0, 0, "R5");
    expect_bit("R5", "sts_wr single", sts_wr_o, 1'b0);

    // R8 pause mid-run
    strobes(50, 1'b1, "R8");
    step(0, 1, 0, 1, 1, 0, "R8");
    strobes(40, 1'b1, "R8");
    step(0, 1, 0, 1, 0, 0, "R8");
    // R9 restart mid-recovery
    strobes(200, 1'b1, "R9");
    step(0, 1, 1, 0, 0, 0, "R9");
    step(0, 1, 0, 1, 0, 0, "R9");
    // R7 full recovery with gaps
    for (int i = 0; i < 129 * 11 + 5; i++) begin
      step(1, 1, 0, 0, 0, 0, "R7");
      step(0, 0, 0, 0, 0, 0, "R7");
    end
    expect_bit("R7", "active after recovery", bus_active_o, 1'b1);

    // R7 second recovery needs full count again
    step(0, 1, 1, 0, 0, 0, "R7");
    step(0, 1, 0, 1, 0, 0, "R7");
    strobes(129 * 11 - 1, 1'b1, "R7");
    expect_bit("R7", "still recovering", bus_active_o, 1'b0);
    strobes(1, 1'b1, "R7");
    expect_bit("R7", "ec pulse", ec_reset_o, 1'b1);

    // random phase
    for (int i = 0; i < 40000; i++) begin
      bit s = ($urandom % 2) == 0;
      bit r = ($urandom % 64) != 0;
      bit b = ($urandom % 6000) == 0;
      bit w = ($urandom % 700) == 0;
      bit d = ($urandom % 4) == 0;
      bit c = ($urandom % 2) == 0;
      step(s, r, b, w, d, c, "R8 random");
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule